// File: doc/BRIEF.md
# First-Order Noise Shaper and Segmented Current-DAC Encoder

This block sits between an oversampling filter and a segmented current-steering DAC and runs at four times the audio sample rate. Each time the rate strobe is high it takes one wide two's complement sample and cuts it to the DAC's narrower word. The bits that are cut off are not simply dropped. They are carried forward and added to the next sample, so the rounding error is pushed toward high frequencies with a first-order (1 - z^-1) shape. The running sum is clipped at the positive end of the input range, so the carried error can never wrap a full-scale sample to a negative value.

The shortened word is then split into the controls of the DAC latch:
- a direction bit taken from the word's sign;
- a thermometer bus that switches on a run of equal coarse current units, starting from the lowest;
- a fine code that selects a fraction of one more coarse unit.

For negative words the lower bits are inverted first. The coarse and fine codes therefore always describe a magnitude, and the direction bit selects the polarity.

All three latch fields come from one output register that loads only on the strobe, so the analog side never sees a mix of fields from two different samples.

Top module: `ns_dac_encoder`

## Requirements
- R1: While reset (`rst_n` low) is asserted, the direction bit, all thermometer lines, the fine code and the carried residue are zero.
- R2: The outputs load only at a rising clock edge where `stb` is high. They reflect the sample presented at that edge and keep their value at every other edge.
- R3: The 15-bit shaped word is floor((sample + residue) / 128). The new residue is (sample + residue) mod 128, an unsigned value from 0 to 127. The residue is zero after reset.
- R4: When sample + residue exceeds 2^21 - 1, the sum is clipped to 2^21 - 1. The shaped word is then 0x3FFF and the residue becomes 127.
- R5: `dir_neg` equals bit 14 of the shaped word, so 1 means a negative word and a sinking current.
- R6: The magnitude is bits 13..0 of the shaped word, with all 14 bits inverted when bit 14 is set. The coarse level is magnitude bits 13..9 and `fine_code` is magnitude bits 8..0.
- R7: Thermometer line i (bit i of `therm`) is high exactly when i is less than the coarse level. Line 31 is therefore never high, and the lit lines always form an unbroken run starting at bit 0.
- R8: A change of `sample` while `stb` is low has no effect on the outputs or on the residue that the next strobed sample uses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stb | input | 1 | Four-times-rate sample strobe, one clock wide |
| sample | input | 22 | Two's complement input sample |
| dir_neg | output | 1 | Current direction: 1 = negative word |
| therm | output | 32 | Coarse-unit thermometer lines, bit 0 lowest |
| fine_code | output | 9 | Fraction of one coarse unit, 0 to 511 |

## Verification
Two situations are hard to reach from the ports. The first is the clip: the residue must already be non-zero when a full-scale positive sample arrives. The stimulus creates this with two strobes of the largest positive value in a row, because the first strobe leaves a residue of 127 and the second strobe would overflow without the clip. The second is the behaviour of the hidden residue. It is observed only through the output pattern of later strobes, so a DC input of half an LSB is strobed several times and the fine code must alternate. Samples that change between strobes must leave that alternation undisturbed.

// File: rtl/nsd_pkg.sv
package nsd_pkg;
   localparam int DEF_IN_W     = 22;
   localparam int DEF_OUT_W    = 15;
   localparam int DEF_COARSE_W = 5;
   localparam int DEF_FINE_W   = 9;

   typedef enum logic {
      POL_SOURCE = 1'b0,
      POL_SINK   = 1'b1
   } polarity_e;
endpackage

// File: rtl/nsd_shaper.sv
module nsd_shaper #(
   parameter int IN_W  = nsd_pkg::DEF_IN_W,
   parameter int OUT_W = nsd_pkg::DEF_OUT_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     stb,
   input  logic [IN_W-1:0]          sample,
   output logic [OUT_W-1:0]         word,
   output logic [IN_W-OUT_W-1:0]    residue
);
   localparam int DROP_W = IN_W - OUT_W;
   localparam int SUM_W  = IN_W + 1;
   localparam logic [IN_W-1:0] POS_MAX = {1'b0, {(IN_W-1){1'b1}}};

   if (DROP_W < 1) begin : g_bad_drop
      $fatal(1, "nsd_shaper: output word must be narrower than input");
   end

   logic [DROP_W-1:0] res_q;
   logic [DROP_W-1:0] res_d;
   logic [SUM_W-1:0]  sum_ext;
   logic              clip;
   logic [IN_W-1:0]   sum_sat;

   // residue is never negative, so only the positive end can overflow
   assign sum_ext = {sample[IN_W-1], sample} + {{(SUM_W-DROP_W){1'b0}}, res_q};
   assign clip    = sum_ext[SUM_W-1] ^ sum_ext[SUM_W-2];

   always_comb begin
      if (clip) sum_sat = POS_MAX;
      else      sum_sat = sum_ext[IN_W-1:0];
   end

   assign word  = sum_sat[IN_W-1:DROP_W];
   assign res_d = sum_sat[DROP_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   res_q <= '0;
      else if (stb) res_q <= res_d;
   end

   assign residue = res_q;
endmodule

// File: rtl/nsd_split.sv
module nsd_split #(
   parameter int OUT_W    = nsd_pkg::DEF_OUT_W,
   parameter int COARSE_W = nsd_pkg::DEF_COARSE_W,
   parameter int FINE_W   = nsd_pkg::DEF_FINE_W
) (
   input  logic [OUT_W-1:0]    word,
   output nsd_pkg::polarity_e  pol,
   output logic [COARSE_W-1:0] coarse,
   output logic [FINE_W-1:0]   fine
);
   localparam int MAG_W = OUT_W - 1;

   if (MAG_W != COARSE_W + FINE_W) begin : g_bad_split
      $fatal(1, "nsd_split: coarse plus fine must equal magnitude width");
   end

   logic             neg;
   logic [MAG_W-1:0] mag;

   assign neg = word[OUT_W-1];
   assign pol = neg ? nsd_pkg::POL_SINK : nsd_pkg::POL_SOURCE;

   for (genvar b = 0; b < MAG_W; b++) begin : g_mag
      assign mag[b] = word[b] ^ neg;
   end

   assign coarse = mag[MAG_W-1:FINE_W];
   assign fine   = mag[FINE_W-1:0];
endmodule

// File: rtl/nsd_therm.sv
module nsd_therm #(
   parameter int COARSE_W = nsd_pkg::DEF_COARSE_W
) (
   input  logic [COARSE_W-1:0]      level,
   output logic [(1<<COARSE_W)-1:0] lines
);
   localparam int N_LINES = 1 << COARSE_W;
   localparam int LVL_W   = COARSE_W + 1;

   if (COARSE_W < 1 || COARSE_W > 8) begin : g_bad_coarse
      $fatal(1, "nsd_therm: coarse width out of supported range");
   end

   logic [LVL_W-1:0] lvl_ext;
   assign lvl_ext = {1'b0, level};

   for (genvar g = 0; g < N_LINES; g++) begin : g_line
      assign lines[g] = lvl_ext > LVL_W'(g);
   end
endmodule

// File: rtl/ns_dac_encoder.sv
module ns_dac_encoder #(
   parameter int IN_W     = nsd_pkg::DEF_IN_W,
   parameter int OUT_W    = nsd_pkg::DEF_OUT_W,
   parameter int COARSE_W = nsd_pkg::DEF_COARSE_W,
   parameter int FINE_W   = nsd_pkg::DEF_FINE_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      stb,
   input  logic [IN_W-1:0]           sample,
   output logic                      dir_neg,
   output logic [(1<<COARSE_W)-1:0]  therm,
   output logic [FINE_W-1:0]         fine_code
);
   localparam int DROP_W  = IN_W - OUT_W;
   localparam int N_LINES = 1 << COARSE_W;

   logic [OUT_W-1:0]    word;
   logic [DROP_W-1:0]   res_q;
   nsd_pkg::polarity_e  pol;
   logic [COARSE_W-1:0] coarse;
   logic [FINE_W-1:0]   fine;
   logic [N_LINES-1:0]  lines;

   nsd_shaper #(.IN_W(IN_W), .OUT_W(OUT_W)) u_shaper (
      .clk     (clk),
      .rst_n   (rst_n),
      .stb     (stb),
      .sample  (sample),
      .word    (word),
      .residue (res_q)
   );

   nsd_split #(.OUT_W(OUT_W), .COARSE_W(COARSE_W), .FINE_W(FINE_W)) u_split (
      .word   (word),
      .pol    (pol),
      .coarse (coarse),
      .fine   (fine)
   );

   nsd_therm #(.COARSE_W(COARSE_W)) u_therm (
      .level (coarse),
      .lines (lines)
   );

   // single latch register: all fields move together
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_neg   <= 1'b0;
         therm     <= '0;
         fine_code <= '0;
      end else if (stb) begin
         dir_neg   <= (pol == nsd_pkg::POL_SINK);
         therm     <= lines;
         fine_code <= fine;
      end
   end
endmodule

// File: rtl/ns_dac_encoder_chk.sv
module ns_dac_encoder_chk #(
   parameter int IN_W     = 22,
   parameter int OUT_W    = 15,
   parameter int COARSE_W = 5,
   parameter int FINE_W   = 9
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       stb,
   input logic [IN_W-1:0]            sample,
   input logic [IN_W-OUT_W-1:0]      res_q,
   input logic                       dir_neg,
   input logic [(1<<COARSE_W)-1:0]   therm,
   input logic [FINE_W-1:0]          fine_code
);
   localparam int N_LINES = 1 << COARSE_W;
   localparam int DROP_W  = IN_W - OUT_W;
   localparam logic [IN_W-1:0] POS_MAX = {1'b0, {(IN_W-1){1'b1}}};

   logic signed [IN_W:0] chk_sum;
   assign chk_sum = $signed({sample[IN_W-1], sample}) + $signed({2'b00, res_q});

   // R1
   p_reset_zero_r1: assert property (@(posedge clk)
      !rst_n |=> (!dir_neg && therm == '0 && fine_code == '0 && res_q == '0));

   // R2
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !stb |=> $stable({dir_neg, therm, fine_code}));

   // R8
   p_res_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !stb |=> $stable(res_q));

   // R5
   p_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
      stb |=> dir_neg == $past(chk_sum < 0));

   // R4
   p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && sample == POS_MAX) |=>
         (!dir_neg && fine_code == '1 && $countones(therm) == N_LINES-1
          && res_q == '1));

   // R7
   p_therm_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((therm & (therm + 1'b1)) == '0) && !therm[N_LINES-1]);
endmodule

bind ns_dac_encoder ns_dac_encoder_chk #(
   .IN_W(IN_W), .OUT_W(OUT_W), .COARSE_W(COARSE_W), .FINE_W(FINE_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .stb       (stb),
   .sample    (sample),
   .res_q     (res_q),
   .dir_neg   (dir_neg),
   .therm     (therm),
   .fine_code (fine_code)
);

// File: tb/ns_dac_encoder_tb.sv
module ns_dac_encoder_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        stb = 1'b0;
   logic [21:0] sample = '0;
   logic        dir_neg;
   logic [31:0] therm;
   logic [8:0]  fine_code;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;
   int m_res = 0;   // bench model of carried residue

   always #5 clk = ~clk;

   ns_dac_encoder u_dut (
      .clk(clk), .rst_n(rst_n), .stb(stb), .sample(sample),
      .dir_neg(dir_neg), .therm(therm), .fine_code(fine_code)
   );

   task automatic check(input string tag, input logic [41:0] act, input logic [41:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual sign/therm/fine=%h expected=%h", tag, act, exp);
      end
   endtask

   // expected latch word from the requirements (R3..R7)
   function automatic logic [41:0] model(input int s);
      int sum; int q; logic [14:0] w; logic [13:0] mag; int c;
      logic [31:0] th;
      sum = s + m_res;
      if (sum > 2097151) sum = 2097151;          // R4
      q = sum >>> 7;                             // R3
      m_res = sum & 127;
      w = q[14:0];
      mag = w[14] ? ~w[13:0] : w[13:0];          // R6
      c = int'(mag[13:9]);
      th = '0;
      for (int i = 0; i < 32; i++) th[i] = (i < c); // R7
      return {w[14], th, mag[8:0]};              // R5
   endfunction

   task automatic strobe(input int s, input string tag);
      logic [41:0] e;
      @(negedge clk);
      sample = s[21:0];
      stb = 1'b1;
      e = model(s);
      @(negedge clk);
      stb = 1'b0;
      check(tag, {dir_neg, therm, fine_code}, e);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      stb = 1'b0;
      m_res = 0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      @(negedge clk);
      rst_n = 1'b0;
      sample = 22'h1FFFFF;
      stb = 1'b1;
      @(negedge clk);
      check("R1 reset state", {dir_neg, therm, fine_code}, 42'd0);
      stb = 1'b0;
      do_reset();
      check("R1 after release", {dir_neg, therm, fine_code}, 42'd0);
   endtask

   task automatic t_half_lsb();
      int ones;
      do_reset();
      ones = 0;
      for (int k = 0; k < 6; k++) begin
         strobe(64, "R3 half-lsb dc");
         ones += int'(fine_code);
      end
      n_checks++;
      if (ones != 3) begin
         n_errors++;
         $display("FAIL R3 shaped average: actual=%0d expected=3", ones);
      end
   endtask

   task automatic t_negative();
      do_reset();
      strobe(-128, "R5 minus one lsb");
      check("R6 minus one zero mag", {dir_neg, therm, fine_code}, {1'b1, 32'h0, 9'h0});
      strobe(-2097152, "R5 negative full scale");
      check("R6 neg full scale", {dir_neg, therm, fine_code}, {1'b1, 32'h7FFFFFFF, 9'h1FF});
      strobe(-(3*512*128 + 5*128) - 128, "R6 neg mid");
   endtask

   task automatic t_sweep();
      do_reset();
      for (int c = 0; c < 32; c++) begin
         strobe((c*512 + c*13) * 128, "R7 coarse sweep");
      end
      strobe(((7*512) + 300) * 128, "R6 fine field");
      check("R6 fine 300", {dir_neg, therm, fine_code}, {1'b0, 32'h7F, 9'd300});
   endtask

   task automatic t_clip();
      do_reset();
      strobe(2097151, "R4 first full scale");
      strobe(2097151, "R4 clip with residue");
      check("R4 no wrap", {dir_neg, therm, fine_code}, {1'b0, 32'h7FFFFFFF, 9'h1FF});
      strobe(0, "R4 residue 127 kept");
   endtask

   task automatic t_no_strobe();
      logic [41:0] held;
      do_reset();
      strobe(64, "R8 prime residue");
      held = {dir_neg, therm, fine_code};
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         sample = 22'(k * 40000 + 77);
         @(negedge clk);
         check("R2 hold without strobe", {dir_neg, therm, fine_code}, held);
      end
      strobe(64, "R8 residue untouched");
      check("R8 carry lands", {dir_neg, therm, fine_code}, {1'b0, 32'h0, 9'd1});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_half_lsb();
      t_negative();
      t_sweep();
      t_clip();
      t_no_strobe();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule